// File: doc/BRIEF.md
# Half-Cycle Selector Switch Sequencer

This block sequences the two slow selector switches of a phase leg that is built from two stacked multilevel modules sharing a midpoint. It receives a stream of sign samples taken from the modulating reference. From that stream it decides which half cycle is in force. It drives the upper and lower selector gates, a clamp request per module and a modulate-enable per module. The upper module's clamp holds its lower switches on, and the lower module's clamp holds its upper switches on. In the positive half cycle the upper module modulates while the lower one sits clamped to the midpoint. In the negative half cycle the roles swap.

Every accepted change of half cycle passes through a timed sequence. First comes a phase in which both modules are clamped and the selectors keep their old setting. Next comes an overlap phase in which the incoming selector is already on while the outgoing one is still on. Only then does the outgoing selector open. The selector therefore switches with no voltage across it. A run-length filter on the sign stream keeps chatter near zero from starting repeated sequences. The lengths of both timed phases are inputs counted in clock cycles.

The sign samples form a valid/ready stream. `samp_rdy` goes high in the first cycle after reset and stays high, so no sample is ever stalled. A sample counts only in a cycle where both `samp_vld` and `samp_rdy` are high. All other pins are plain levels, and every output is registered.

Top module: `hcss_sel_seq`

## Requirements
- R1: During and after reset, until the first sign is accepted, the outputs are as follows:
  - both selectors are off;
  - both clamps are asserted;
  - both modulate-enables are low;
  - busy is low;
  - `state_o` is 0 (idle).

  `samp_rdy` is high from the first clock after reset and stays high.
- R2: In the positive steady state (`state_o`=3) the outputs are as follows:
  - the upper selector is on and the lower selector is off;
  - the upper module's modulate-enable is high;
  - the lower clamp is asserted and the upper clamp is released;
  - busy is low.
- R3: In the negative steady state (`state_o`=4) the outputs are as follows:
  - the lower selector is on and the upper selector is off;
  - the lower module's modulate-enable is high;
  - the upper clamp is asserted and the lower clamp is released;
  - busy is low.
- R4: A sign (`samp_neg`=1 means negative) is accepted only after FILT_LEN consecutive accepted samples of that same sign. A shorter run followed by the other sign changes no output.
- R5: An accepted sign that differs from the current half cycle first enters the clamp phase (`state_o`=1). The clamp phase has these properties:
  - it lasts `mid_len` cycles, with 0 treated as 1;
  - both clamps are asserted;
  - both modulate-enables are low;
  - the selectors keep their previous values.
- R6: The clamp phase is followed by the overlap phase (`state_o`=2). The overlap phase has these properties:
  - it lasts `ovl_len` cycles, with 0 treated as 1;
  - the incoming selector is on and the outgoing selector is still on;
  - the outgoing selector opens only when the steady state is entered.
- R7: The first sign accepted after reset goes through the clamp phase with both selectors off. It then goes through the overlap phase with only the incoming selector on, and then enters its steady state.
- R8: Busy is high exactly in the clamp and overlap phases. Both modulate-enables stay low throughout, and the two modulate-enables are never high together.
- R9: A sign accepted during a transition does not alter that transition. If the accepted sign differs once the steady state is reached, the next transition starts after exactly one cycle in that steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | Sign sample valid |
| samp_neg | input | 1 | Sign sample, 1 = negative reference |
| samp_rdy | output | 1 | Sample stream ready, high after reset |
| mid_len | input | CW | Clamp phase length in cycles (0 acts as 1) |
| ovl_len | input | CW | Selector overlap length in cycles (0 acts as 1) |
| sel_up | output | 1 | Upper selector gate |
| sel_dn | output | 1 | Lower selector gate |
| up_mod_en | output | 1 | Upper module may modulate |
| dn_mod_en | output | 1 | Lower module may modulate |
| up_clamp | output | 1 | Upper module holds its lower switches on |
| dn_clamp | output | 1 | Lower module holds its upper switches on |
| busy | output | 1 | Transition in progress |
| state_o | output | 3 | 0 idle, 1 clamp, 2 overlap, 3 positive, 4 negative |

## Verification
The bench builds the block with FILT_LEN=3 and CW=8. A three-sample run is short enough to cut with a two-sample burst, which exposes the chatter filter, and it is long enough to land a full opposite-sign acceptance inside a clamp phase of four or five cycles, which reaches the mid-transition reversal case. The phase lengths are driven at run time: 5 and 2 for the first entry, 0 and 3 to hit the zero-as-one floor, then 4 and 2 for the back-to-back reversal.

// File: rtl/hcss_pkg.sv
package hcss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MID  = 3'd1,
    ST_OVL  = 3'd2,
    ST_POS  = 3'd3,
    ST_NEG  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/hcss_sign_filter.sv
// Run-length filter: a sign is accepted after FILT_LEN equal samples in a row.
module hcss_sign_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_neg,
  output logic acc_vld,
  output logic acc_neg
);
  localparam int RW = $clog2(FILT_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(FILT_LEN);

  logic [RW-1:0] run_q, run_nx;
  logic          last_q, have_q, same;

  always_comb begin
    same = have_q && (in_neg == last_q);
    if (!same)               run_nx = RW'(1);
    else if (run_q == RUN_MAX) run_nx = run_q;
    else                     run_nx = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      last_q  <= 1'b0;
      have_q  <= 1'b0;
      acc_vld <= 1'b0;
      acc_neg <= 1'b0;
    end else if (in_vld) begin
      run_q  <= run_nx;
      last_q <= in_neg;
      have_q <= 1'b1;
      if (run_nx == RUN_MAX) begin
        acc_vld <= 1'b1;
        acc_neg <= in_neg;
      end
    end
  end
endmodule

// File: rtl/hcss_timer.sv
// Down-counter: a load of len makes done true in the len-th cycle (0 acts as 1).
module hcss_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= (len == '0) ? '0 : len - CW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/hcss_seq_fsm.sv
// Half-cycle sequencer: steady -> clamp phase -> overlap phase -> steady.
module hcss_seq_fsm
  import hcss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_vld,
  input  logic       acc_neg,
  input  logic       tmr_done,
  output logic       tmr_load,
  output logic       tmr_use_ovl,
  output seq_state_e st_q,
  output logic       tgt_neg_q,
  output logic       prev_up_q,
  output logic       prev_dn_q
);
  seq_state_e st_nx;
  logic       start;

  always_comb begin
    st_nx = st_q;
    start = 1'b0;
    unique case (st_q)
      ST_IDLE: if (acc_vld)             start = 1'b1;
      ST_POS:  if (acc_vld && acc_neg)  start = 1'b1;
      ST_NEG:  if (acc_vld && !acc_neg) start = 1'b1;
      ST_MID:  if (tmr_done) st_nx = ST_OVL;
      ST_OVL:  if (tmr_done) st_nx = tgt_neg_q ? ST_NEG : ST_POS;
      default: st_nx = ST_IDLE;
    endcase
    if (start) st_nx = ST_MID;
  end

  assign tmr_load    = start || (st_q == ST_MID && st_nx == ST_OVL);
  assign tmr_use_ovl = (st_nx == ST_OVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tgt_neg_q <= 1'b0;
      prev_up_q <= 1'b0;
      prev_dn_q <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (start) begin
        tgt_neg_q <= acc_neg;
        prev_up_q <= (st_q == ST_POS);
        prev_dn_q <= (st_q == ST_NEG);
      end
    end
  end
endmodule

// File: rtl/hcss_gate_decode.sv
// Registered decode of sequencer state into gate, clamp and enable levels.
module hcss_gate_decode
  import hcss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e st,
  input  logic       tgt_neg,
  input  logic       prev_up,
  input  logic       prev_dn,
  output logic       sel_up,
  output logic       sel_dn,
  output logic       up_mod_en,
  output logic       dn_mod_en,
  output logic       up_clamp,
  output logic       dn_clamp,
  output logic       busy,
  output logic [2:0] state_o
);
  typedef struct packed {
    logic su, sd, um, dm, uc, dc, bz;
  } pins_t;

  pins_t nx, q;

  always_comb begin
    nx = '{su:1'b0, sd:1'b0, um:1'b0, dm:1'b0, uc:1'b1, dc:1'b1, bz:1'b0};
    unique case (st)
      ST_MID: begin
        nx.su = prev_up;
        nx.sd = prev_dn;
        nx.bz = 1'b1;
      end
      ST_OVL: begin
        nx.su = prev_up | ~tgt_neg;
        nx.sd = prev_dn | tgt_neg;
        nx.bz = 1'b1;
      end
      ST_POS: begin
        nx.su = 1'b1;
        nx.um = 1'b1;
        nx.uc = 1'b0;
      end
      ST_NEG: begin
        nx.sd = 1'b1;
        nx.dm = 1'b1;
        nx.dc = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '{su:1'b0, sd:1'b0, um:1'b0, dm:1'b0, uc:1'b1, dc:1'b1, bz:1'b0};
      state_o <= 3'd0;
    end else begin
      q       <= nx;
      state_o <= st;
    end
  end

  assign sel_up    = q.su;
  assign sel_dn    = q.sd;
  assign up_mod_en = q.um;
  assign dn_mod_en = q.dm;
  assign up_clamp  = q.uc;
  assign dn_clamp  = q.dc;
  assign busy      = q.bz;
endmodule

// File: rtl/hcss_sel_seq.sv
module hcss_sel_seq
  import hcss_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int CW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_vld,
  input  logic          samp_neg,
  output logic          samp_rdy,
  input  logic [CW-1:0] mid_len,
  input  logic [CW-1:0] ovl_len,
  output logic          sel_up,
  output logic          sel_dn,
  output logic          up_mod_en,
  output logic          dn_mod_en,
  output logic          up_clamp,
  output logic          dn_clamp,
  output logic          busy,
  output logic [2:0]    state_o
);
  logic       acc_vld, acc_neg, tmr_done, tmr_load, tmr_use_ovl;
  logic       tgt_neg, prev_up, prev_dn;
  seq_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_rdy <= 1'b0;
    else        samp_rdy <= 1'b1;
  end

  hcss_sign_filter #(.FILT_LEN(FILT_LEN)) filt_i (
    .clk(clk), .rst_n(rst_n),
    .in_vld(samp_vld && samp_rdy), .in_neg(samp_neg),
    .acc_vld(acc_vld), .acc_neg(acc_neg)
  );

  hcss_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .len(tmr_use_ovl ? ovl_len : mid_len), .done(tmr_done)
  );

  hcss_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_neg(acc_neg),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_use_ovl(tmr_use_ovl),
    .st_q(st), .tgt_neg_q(tgt_neg), .prev_up_q(prev_up), .prev_dn_q(prev_dn)
  );

  hcss_gate_decode dec_i (
    .clk(clk), .rst_n(rst_n), .st(st), .tgt_neg(tgt_neg),
    .prev_up(prev_up), .prev_dn(prev_dn),
    .sel_up(sel_up), .sel_dn(sel_dn), .up_mod_en(up_mod_en),
    .dn_mod_en(dn_mod_en), .up_clamp(up_clamp), .dn_clamp(dn_clamp),
    .busy(busy), .state_o(state_o)
  );
endmodule

// File: rtl/hcss_sel_seq_chk.sv
module hcss_sel_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_up,
  input logic       sel_dn,
  input logic       up_mod_en,
  input logic       dn_mod_en,
  input logic       up_clamp,
  input logic       dn_clamp,
  input logic       busy,
  input logic [2:0] state_o
);
  assert_idle_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (up_clamp && dn_clamp && !sel_up && !sel_dn && !busy));

  assert_pos_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    up_mod_en |-> (sel_up && !sel_dn && dn_clamp && !up_clamp));

  assert_neg_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_mod_en |-> (sel_dn && !sel_up && up_clamp && !dn_clamp));

  assert_sel_only_in_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_up) || !$stable(sel_dn)) |-> $past(busy));

  assert_up_make_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_up) |-> ($past(sel_dn) && sel_dn));

  assert_dn_make_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_dn) |-> ($past(sel_up) && sel_up));

  assert_busy_no_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!up_mod_en && !dn_mod_en));

  assert_mod_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({up_mod_en, dn_mod_en}) <= 1);
endmodule

bind hcss_sel_seq hcss_sel_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel_up(sel_up), .sel_dn(sel_dn),
  .up_mod_en(up_mod_en), .dn_mod_en(dn_mod_en), .up_clamp(up_clamp),
  .dn_clamp(dn_clamp), .busy(busy), .state_o(state_o)
);

// File: tb/hcss_sel_seq_tb_top.sv
`timescale 1ns/1ps
module hcss_sel_seq_tb_top;
  localparam int FILT_LEN = 3;
  localparam int CW       = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_vld = 1'b0, samp_neg = 1'b0;
  logic          samp_rdy;
  logic [CW-1:0] mid_len = '0, ovl_len = '0;
  logic          sel_up, sel_dn, up_mod_en, dn_mod_en, up_clamp, dn_clamp, busy;
  logic [2:0]    state_o;

  always #4 clk = ~clk;

  hcss_sel_seq #(.FILT_LEN(FILT_LEN), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_neg(samp_neg),
    .samp_rdy(samp_rdy), .mid_len(mid_len), .ovl_len(ovl_len),
    .sel_up(sel_up), .sel_dn(sel_dn), .up_mod_en(up_mod_en),
    .dn_mod_en(dn_mod_en), .up_clamp(up_clamp), .dn_clamp(dn_clamp),
    .busy(busy), .state_o(state_o)
  );

  typedef struct {
    logic [9:0] v;
    int         dur;
    string      req;
  } item_t;

  item_t queue_q[$];
  int    n_chk = 0, n_bad = 0;
  bit    mon_on = 1'b0;

  function automatic logic [9:0] mk(input int st, input bit su, sd, um, dm, uc, dc, bz);
    return {3'(st), su, sd, um, dm, uc, dc, bz};
  endfunction

  function automatic logic [9:0] pins();
    return {state_o, sel_up, sel_dn, up_mod_en, dn_mod_en, up_clamp, dn_clamp, busy};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v, input int dur, input string req);
    item_t it;
    it.v = v; it.dur = dur; it.req = req;
    queue_q.push_back(it);
  endtask

  task automatic send(input bit neg, input int n);
    repeat (n) begin
      @(negedge clk);
      samp_vld = 1'b1;
      samp_neg = neg;
    end
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every change of the pin vector is compared against the queue head.
  initial begin
    logic [9:0] prev_v;
    int held;
    wait (mon_on);
    prev_v = pins();
    held = 1;
    forever begin
      @(negedge clk);
      if (pins() !== prev_v) begin
        if (queue_q.size() == 0) begin
          check("R4 unexpected change", 32'(pins()), 32'(prev_v));
        end else begin
          item_t it;
          it = queue_q.pop_front();
          check(it.req, 32'(pins()), 32'(it.v));
          if (it.dur != 0) check({it.req, " duration"}, 32'(held), 32'(it.dur));
        end
        held = 1;
        prev_v = pins();
      end else begin
        held++;
      end
    end
  end

  task automatic run_all();
    idle(3);
    check("R1 reset pins", 32'(pins()), 32'(mk(0, 0, 0, 0, 0, 1, 1, 0)));
    rst_n = 1'b1;
    idle(2);
    check("R1 ready", 32'(samp_rdy), 32'd1);
    check("R1 idle after reset", 32'(pins()), 32'(mk(0, 0, 0, 0, 0, 1, 1, 0)));
    mon_on = 1'b1;

    // First sign after reset: positive
    mid_len = 8'd5; ovl_len = 8'd2;
    push(mk(1, 0, 0, 0, 0, 1, 1, 1), 0, "R7 clamp from idle");
    push(mk(2, 1, 0, 0, 0, 1, 1, 1), 5, "R7 overlap from idle");
    push(mk(3, 1, 0, 1, 0, 0, 1, 0), 2, "R2 positive steady");
    send(1'b0, 3);
    idle(20);

    // Chatter: two negatives then a positive, no transition
    send(1'b1, 2);
    send(1'b0, 1);
    idle(15);
    check("R4 chatter ignored", 32'(pins()), 32'(mk(3, 1, 0, 1, 0, 0, 1, 0)));

    // Positive -> negative with zero clamp length
    mid_len = 8'd0; ovl_len = 8'd3;
    push(mk(1, 1, 0, 0, 0, 1, 1, 1), 0, "R5 clamp phase");
    push(mk(2, 1, 1, 0, 0, 1, 1, 1), 1, "R6 overlap phase");
    push(mk(4, 0, 1, 0, 1, 1, 0, 0), 3, "R3 negative steady");
    send(1'b1, 3);
    idle(20);

    // Reversal accepted mid-transition
    mid_len = 8'd4; ovl_len = 8'd2;
    push(mk(1, 0, 1, 0, 0, 1, 1, 1), 0, "R9 clamp toward positive");
    push(mk(2, 1, 1, 0, 0, 1, 1, 1), 4, "R9 overlap toward positive");
    push(mk(3, 1, 0, 1, 0, 0, 1, 0), 2, "R9 positive reached");
    push(mk(1, 1, 0, 0, 0, 1, 1, 1), 1, "R9 one-cycle steady");
    push(mk(2, 1, 1, 0, 0, 1, 1, 1), 4, "R9 overlap toward negative");
    push(mk(4, 0, 1, 0, 1, 1, 0, 0), 2, "R9 negative reached");
    send(1'b0, 3);
    send(1'b1, 3);
    idle(30);

    check("R8 settled not busy", 32'(busy), 32'd0);
    check("R8 all expected changes seen", 32'(queue_q.size()), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule